// File: doc/BRIEF.md
# Hit Frame Memory with Serial Readout

This block sits behind the discriminators of a 64-channel front end. While an acquisition window is open, each trigger strobe captures one wide frame. A frame holds an 8-bit header, the 24-bit bunch-crossing number of the triggering cycle, and the 2-bit discriminator state of every channel. The block counts the bunch crossings itself. The counter restarts at zero when a window opens and advances once per clock while the window stays open.

Up to 128 frames are kept, which is 20480 bits. When the memory is full, a flag rises and later triggers are dropped. After the window closes, a readout request shifts the whole memory out on one serial line, one bit per clock, with a valid qualifier. The newest frame goes first. A one-cycle done pulse marks the end of the readout and empties the memory, so the next window writes from the first slot again.

Top module: `hit_frame_mem`

## Requirements
- R1: A cycle with `acq_en_i`=1, `trig_i`=1, no readout in progress and fewer than 128 frames stored appends the frame {`hdr_i`, BCID, `disc_i`}, 160 bits with the header in bits 159:152, BCID in 151:128 and channel c's two bits at `disc_i`[2c+1:2c].
- R2: The BCID is 0 in the first cycle that `acq_en_i` is high after a low cycle, and it rises by one in each further consecutive cycle with `acq_en_i` high. A trigger records the BCID of its own cycle.
- R3: `full_o` is high exactly while 128 frames are stored.
- R4: A trigger is ignored while `acq_en_i` is low or while the memory is full.
- R5: `rd_start_i` high in a cycle with `acq_en_i` low and no readout running starts a readout. The first valid bit appears on the outputs after the next clock edge.
- R6: Readout sends frames from newest to oldest. Each frame's 160 bits go most significant bit first: header, BCID, then channel 63 down to channel 0 with the upper bit of each pair first.
- R7: `sdata_vld_o` stays high for exactly 160 times the number of stored frames, in consecutive cycles. `sdata_o` is 0 whenever `sdata_vld_o` is low.
- R8: `rd_done_o` is a one-cycle pulse in the cycle after the last valid bit. With the pulse the memory becomes empty and `full_o` drops, so the next window stores its first frame as the oldest.
- R9: A readout request with an empty memory produces the done pulse in the next cycle and no valid bits.
- R10: While a readout runs, `rd_start_i` and triggers are ignored, even when `acq_en_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bunch crossing per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| acq_en_i | input | 1 | Acquisition window open |
| trig_i | input | 1 | Trigger strobe, stores one frame |
| hdr_i | input | 8 | Header value stored with the frame |
| disc_i | input | 128 | Discriminator states, channel c at bits 2c+1:2c |
| rd_start_i | input | 1 | Readout request |
| sdata_o | output | 1 | Serial frame data |
| sdata_vld_o | output | 1 | Serial data qualifier |
| full_o | output | 1 | 128 frames stored |
| rd_done_o | output | 1 | One-cycle end-of-readout pulse |

## Verification
The bench goes after these corner cases:
- Filling past capacity. A design that wrapped its write pointer or missed the limit would drop the oldest frames or lengthen the serial stream.
- Readout of an empty memory. An off-by-one on the read index would then emit a stray 160-bit frame instead of only the done pulse.
- Readout requests and triggers during a running readout. A design that acted on them would restart the stream or corrupt the frame count.
- Back-to-back windows. A BCID that failed to restart would shift every recorded timestamp, and a pointer left uncleared after done would put the second window's frames behind stale ones.

// File: rtl/hfm_pkg.sv
package hfm_pkg;
    localparam int NCH_DEF    = 64;
    localparam int DBITS_DEF  = 2;
    localparam int BCID_W_DEF = 24;
    localparam int HDR_W_DEF  = 8;
    localparam int DEPTH_DEF  = 128;

    typedef enum logic [1:0] {
        RD_IDLE   = 2'd0,
        RD_SHIFT  = 2'd1,
        RD_FINISH = 2'd2
    } rd_state_e;
endpackage

// File: rtl/hfm_bcid_ctr.sv
module hfm_bcid_ctr #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acq_en_i,
    output logic [W-1:0] bcid_o
);
    typedef struct packed {
        logic         acq;
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] cur;

    always_comb begin
        st_d = st_q;
        // first open cycle reads zero, each further open cycle one more
        cur = st_q.acq ? st_q.cnt + W'(1) : '0;
        st_d.acq = acq_en_i;
        if (acq_en_i) begin
            st_d.cnt = cur;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bcid_o = cur;
endmodule

// File: rtl/hfm_frame_store.sv
module hfm_frame_store #(
    parameter int DEPTH = 128,
    parameter int FW    = 160,
    parameter int AW    = $clog2(DEPTH),
    parameter int BW    = $clog2(FW)
) (
    input  logic          clk,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [FW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    input  logic [BW-1:0] rd_bit_i,
    output logic          rd_bit_o
);
    logic [FW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    // single-bit read port feeding the serializer
    assign rd_bit_o = mem_q[rd_addr_i][rd_bit_i];
endmodule

// File: rtl/hfm_ctrl.sv
module hfm_ctrl
    import hfm_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int FW    = 160,
    parameter int AW    = $clog2(DEPTH),
    parameter int BW    = $clog2(FW),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acq_en_i,
    input  logic          trig_i,
    input  logic          rd_start_i,
    input  logic          mem_bit_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [AW-1:0] rd_addr_o,
    output logic [BW-1:0] rd_bit_o,
    output logic          sdata_o,
    output logic          vld_o,
    output logic          done_o,
    output logic          full_o
);
    typedef struct packed {
        rd_state_e     state;
        logic [CW-1:0] count;
        logic [AW-1:0] idx;
        logic [BW-1:0] bitp;
        logic          sdata;
        logic          vld;
        logic          done;
    } st_t;

    st_t st_d, st_q;
    logic is_full;

    assign is_full = (st_q.count == CW'(DEPTH));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        wr_en_o   = 1'b0;
        unique case (st_q.state)
            RD_IDLE: begin
                st_d.vld   = 1'b0;
                st_d.sdata = 1'b0;
                if (acq_en_i && trig_i && !is_full) begin
                    wr_en_o    = 1'b1;
                    st_d.count = st_q.count + CW'(1);
                end else if (!acq_en_i && rd_start_i) begin
                    st_d.state = (st_q.count == '0) ? RD_FINISH : RD_SHIFT;
                    st_d.idx   = AW'(st_q.count - CW'(1));
                    st_d.bitp  = BW'(FW - 1);
                end
            end
            RD_SHIFT: begin
                st_d.vld   = 1'b1;
                st_d.sdata = mem_bit_i;
                if (st_q.bitp == '0) begin
                    st_d.bitp = BW'(FW - 1);
                    if (st_q.idx == '0) begin
                        st_d.state = RD_FINISH;
                    end else begin
                        st_d.idx = st_q.idx - AW'(1);
                    end
                end else begin
                    st_d.bitp = st_q.bitp - BW'(1);
                end
            end
            RD_FINISH: begin
                st_d.vld   = 1'b0;
                st_d.sdata = 1'b0;
                st_d.done  = 1'b1;
                st_d.count = '0;
                st_d.state = RD_IDLE;
            end
            default: begin
                st_d.state = RD_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= RD_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_addr_o = st_q.count[AW-1:0];
    assign rd_addr_o = st_q.idx;
    assign rd_bit_o  = st_q.bitp;
    assign sdata_o   = st_q.sdata;
    assign vld_o     = st_q.vld;
    assign done_o    = st_q.done;
    assign full_o    = is_full;
endmodule

// File: rtl/hit_frame_mem.sv
module hit_frame_mem
    import hfm_pkg::*;
#(
    parameter int NCH    = NCH_DEF,
    parameter int DBITS  = DBITS_DEF,
    parameter int BCID_W = BCID_W_DEF,
    parameter int HDR_W  = HDR_W_DEF,
    parameter int DEPTH  = DEPTH_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acq_en_i,
    input  logic                   trig_i,
    input  logic [HDR_W-1:0]       hdr_i,
    input  logic [NCH*DBITS-1:0]   disc_i,
    input  logic                   rd_start_i,
    output logic                   sdata_o,
    output logic                   sdata_vld_o,
    output logic                   full_o,
    output logic                   rd_done_o
);
    localparam int CH_W = NCH * DBITS;
    localparam int FW   = HDR_W + BCID_W + CH_W;
    localparam int AW   = $clog2(DEPTH);
    localparam int BW   = $clog2(FW);
    localparam int CW   = $clog2(DEPTH + 1);

    logic [BCID_W-1:0] bcid_now;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [AW-1:0]     rd_addr;
    logic [BW-1:0]     rd_bit;
    logic              mem_bit;
    logic [FW-1:0]     frame;

    assign frame = {hdr_i, bcid_now, disc_i};

    hfm_bcid_ctr #(.W(BCID_W)) u_bcid (
        .clk      (clk),
        .rst_n    (rst_n),
        .acq_en_i (acq_en_i),
        .bcid_o   (bcid_now)
    );

    hfm_frame_store #(.DEPTH(DEPTH), .FW(FW), .AW(AW), .BW(BW)) u_store (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (frame),
        .rd_addr_i (rd_addr),
        .rd_bit_i  (rd_bit),
        .rd_bit_o  (mem_bit)
    );

    hfm_ctrl #(.DEPTH(DEPTH), .FW(FW), .AW(AW), .BW(BW), .CW(CW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .acq_en_i   (acq_en_i),
        .trig_i     (trig_i),
        .rd_start_i (rd_start_i),
        .mem_bit_i  (mem_bit),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .rd_addr_o  (rd_addr),
        .rd_bit_o   (rd_bit),
        .sdata_o    (sdata_o),
        .vld_o      (sdata_vld_o),
        .done_o     (rd_done_o),
        .full_o     (full_o)
    );
endmodule

// File: rtl/hfm_chk.sv
module hfm_chk #(
    parameter int BCID_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acq_en_i,
    input logic [BCID_W-1:0] bcid,
    input logic              wr_en,
    input logic              full_o,
    input logic              vld_o,
    input logic              sdata_o,
    input logic              done_o
);
    // R2
    bcid_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_en_i && $past(acq_en_i) && $past(rst_n) |-> bcid == $past(bcid) + BCID_W'(1));

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |=> full_o || done_o);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full_o);

    // R7
    stream_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> vld_o || done_o);

    // R7
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o |-> !sdata_o);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !vld_o && !full_o);
endmodule

bind hit_frame_mem hfm_chk #(.BCID_W(BCID_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acq_en_i (acq_en_i),
    .bcid     (bcid_now),
    .wr_en    (wr_en),
    .full_o   (full_o),
    .vld_o    (sdata_vld_o),
    .sdata_o  (sdata_o),
    .done_o   (rd_done_o)
);

// File: tb/hit_frame_mem_test.sv
module hit_frame_mem_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 128;
    localparam int FWID       = 160;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         acq_en, trig, rd_start;
    logic [7:0]   hdr;
    logic [127:0] disc;
    logic         sdata, vld, full, done;

    int n_checks = 0;
    int n_err    = 0;
    int cycles   = 0;
    bit finished = 0;
    string scen  = "R7";

    // behavioural reference state
    logic [FWID-1:0] frames [$];
    bit              stream [$];
    int              m_state = 0;  // 0 idle, 1 shifting, 2 ending
    int unsigned     m_bcid = 0;
    bit              m_prev_acq = 0;
    bit              e_vld = 0, e_sdata = 0, e_done = 0, e_full = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hit_frame_mem uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .acq_en_i    (acq_en),
        .trig_i      (trig),
        .hdr_i       (hdr),
        .disc_i      (disc),
        .rd_start_i  (rd_start),
        .sdata_o     (sdata),
        .sdata_vld_o (vld),
        .full_o      (full),
        .rd_done_o   (done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            frames.delete(); stream.delete();
            m_state = 0; m_bcid = 0; m_prev_acq = 0;
            e_vld = 0; e_sdata = 0; e_done = 0; e_full = 0;
        end else begin
            int unsigned bnow;
            bnow = 0;
            if (acq_en) begin
                bnow = m_prev_acq ? ((m_bcid + 1) & 32'h00FF_FFFF) : 0;
                m_bcid = bnow;
            end
            m_prev_acq = acq_en;
            e_done = 0;
            if (m_state == 1) begin
                e_vld = 1;
                e_sdata = stream.pop_front();
                if (stream.size() == 0) m_state = 2;
            end else if (m_state == 2) begin
                e_vld = 0; e_sdata = 0; e_done = 1;
                frames.delete();
                m_state = 0;
            end else begin
                e_vld = 0; e_sdata = 0;
                if (acq_en && trig && frames.size() < DEPTH) begin
                    frames.push_back({hdr, bnow[23:0], disc});
                end else if (!acq_en && rd_start) begin
                    for (int i = frames.size() - 1; i >= 0; i--)
                        for (int b = FWID - 1; b >= 0; b--)
                            stream.push_back(frames[i][b]);
                    m_state = (frames.size() == 0) ? 2 : 1;
                end
            end
            e_full = (frames.size() == DEPTH);
        end
    end

    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            chk($sformatf("R7 valid [%s]", scen), 32'(vld), 32'(e_vld));
            chk($sformatf("R6 data [%s]", scen), 32'(sdata), 32'(e_sdata));
            chk($sformatf("R8 done [%s]", scen), 32'(done), 32'(e_done));
            chk($sformatf("R3 full [%s]", scen), 32'(full), 32'(e_full));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog expired act=%0d exp<150000", cycles);
            summary();
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            acq_en = 0; trig = 0; rd_start = 0;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        acq_en = 0; trig = 0; rd_start = 1;
        @(negedge clk);
        rd_start = 0;
    endtask

    initial begin
        rst_n = 0; acq_en = 0; trig = 0; rd_start = 0; hdr = 8'h00; disc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R7 reset valid", 32'(vld), 0);
        chk("R8 reset done", 32'(done), 0);
        chk("R3 reset full", 32'(full), 0);

        // R9: empty memory readout
        scen = "R9";
        pulse_start();
        idle(4);

        // R1 / R2: several channel patterns in one window
        scen = "R1";
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            acq_en = 1; rd_start = 0;
            trig = (i == 0 || i == 3 || i == 4 || i == 11);
            hdr = 8'h5A ^ 8'(i);
            case (i)
                0:  disc = '1;
                3:  disc = {8{16'hAAAA}};
                4:  disc = 128'h1 << 11;
                default: disc = {$urandom, $urandom, $urandom, $urandom};
            endcase
        end
        idle(3);
        scen = "R6";
        pulse_start();
        idle(4 * FWID + 6);

        // R2: a second window restarts the crossing count
        scen = "R2";
        idle(2);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            acq_en = 1; trig = (i == 6 || i == 2); hdr = 8'(i);
            disc = {$urandom, $urandom, $urandom, $urandom};
        end
        idle(2);
        scen = "R5";
        pulse_start();
        idle(2 * FWID + 6);

        // R10: start and triggers during a running readout
        scen = "R10";
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            acq_en = 1; trig = 1; hdr = 8'hC0 + 8'(i);
            disc = {$urandom, $urandom, $urandom, $urandom};
        end
        idle(1);
        pulse_start();
        idle(10);
        @(negedge clk); rd_start = 1;
        @(negedge clk); rd_start = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            acq_en = 1; trig = 1; hdr = 8'hEE;
        end
        idle(5 * FWID + 10);

        // R3 / R4: overfill, then triggers with the window closed
        scen = "R3";
        for (int i = 0; i < 140; i++) begin
            @(negedge clk);
            acq_en = 1; trig = 1; hdr = 8'(i);
            disc = {$urandom, $urandom, $urandom, $urandom};
        end
        @(negedge clk);
        acq_en = 0; trig = 0;
        chk("R3 full after overfill", 32'(full), 1);
        scen = "R4";
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            acq_en = 0; trig = 1; hdr = 8'hFF;
        end
        idle(2);
        pulse_start();
        idle(DEPTH * FWID + 10);
        chk("R8 full cleared", 32'(full), 0);

        // R8: fresh window after the done pulse
        scen = "R8";
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            acq_en = 1; trig = (i != 1); hdr = 8'h30 + 8'(i);
            disc = {$urandom, $urandom, $urandom, $urandom};
        end
        idle(2);
        pulse_start();
        idle(2 * FWID + 6);

        summary();
    end
endmodule